// File: doc/BRIEF.md
# Reed–Solomon ECC Control and Status Unit

This block is the host-facing register front end and sequencer of a NAND Reed–Solomon ECC engine. The host programs a control word that enables the engine, selects Reed–Solomon operation, chooses between encoding and decoding, and can pulse a local reset. Data bytes written to a data port are forwarded one at a time to the codec, and a counter tracks how many bytes of the 512-byte codeword have been taken. The unit holds the nine parity bytes, a status word with sticky finish flags and an error count, an interrupt-enable word, and up to four error location reports.

The unit follows the direction bit. When encoding, the codec's completion loads the computed parity into the parity registers and sets the encode-finished flag. A computed parity that equals the parity of an all-0xFF codeword is replaced by nine 0xFF bytes. When decoding, the host first writes the parity it read from the flash and then sets parity-ready. This sends one start pulse to the codec. The codec's completion then sets the decode-finished flag and loads the error flags, the error count and the error reports. The arithmetic codec itself sits outside this unit.

Top module: `ecc_ctrl_status`

## Requirements
- R1: After reset every readable register (control 0x100, parity words 0x108/0x10C/0x110, status 0x114, interrupt enable 0x118, error reports from 0x11C) reads 0, and `irq` and `cdc_start` are low.
- R2: The control word at 0x100 has enable in bit 0, reset in bit 1, RS select in bit 2, encode (1) or decode (0) in bit 3, and parity-ready in bit 4. It reads back as written. `cdc_rs_sel` and `cdc_encode` follow bits 2 and 3.
- R3: Writing control with bit 1 set clears the parity bytes, the error reports and the data byte counter. It drives `cdc_clear` high for one cycle, and bit 1 reads 0 again afterwards.
- R4: A write to 0x104 with byte strobe 0 while enable is set presents that byte on `cdc_byte` with `cdc_byte_vld` high in the next cycle. While enable is clear the write is ignored.
- R5: When the 512th byte of a codeword is accepted, status bit 4 (pad finished) is set. Further data writes are not forwarded until a reset through control bit 1.
- R6: A codec completion while enabled in encode mode loads parity byte i (codec bits 8i+7:8i) into the byte at address 0x108+i, in little-endian lanes of the three words, and sets status bit 2.
- R7: If the computed parity is CD 9D 90 58 F4 8B FF B7 6F (byte 0 first), all nine parity bytes read 0xFF.
- R8: In decode mode with enable set, a control write that raises parity-ready from 0 to 1 gives exactly one `cdc_start` pulse in the next cycle. During that pulse `cdc_par_out` carries the host-written parity bytes, which can be written per byte through the strobes. In encode mode no pulse is produced.
- R9: A codec completion while enabled in decode mode sets status bit 3, loads bit 0 (error), bit 1 (uncorrectable) and bits 31:29 (error count), and loads error report i at 0x11C+4i. Reports at or beyond the count read 0.
- R10: A codec completion while enable is clear changes neither the status word nor the error reports.
- R11: A write to the status word clears every flag and count bit written as 0 and keeps those written as 1, so writing 0 clears everything. A flag set by the codec in the same cycle wins.
- R12: `irq` is high when any of status bits 4:2 is set with the same bit set in the interrupt-enable word at 0x118.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane strobes for writes |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Masked OR of the finish flags |
| cdc_clear | output | 1 | One-cycle local reset to the codec |
| cdc_rs_sel | output | 1 | RS select bit |
| cdc_encode | output | 1 | 1 encode, 0 decode |
| cdc_byte_vld | output | 1 | Data byte valid to the codec |
| cdc_byte | output | 8 | Data byte to the codec |
| cdc_start | output | 1 | Decode start pulse |
| cdc_par_out | output | 72 | Stored parity to the codec, byte 0 in bits 7:0 |
| cdc_done | input | 1 | Codec completion pulse |
| cdc_par_in | input | 72 | Computed parity, byte 0 in bits 7:0 |
| cdc_err | input | 1 | Decode found errors |
| cdc_uncor | input | 1 | Decode errors are uncorrectable |
| cdc_err_cnt | input | 3 | Number of error reports |
| cdc_err_rpt | input | 128 | Error reports, report i in bits 32i+31:32i |

## Verification
A register write takes effect at the clock edge that samples it. So `cdc_clear`, `cdc_start`, `cdc_byte_vld` and the parity output are checked half a cycle after that edge, and `cdc_start` is checked again one cycle later to confirm that it dropped. Codec completions update status, parity, reports and `irq` at the edge that samples `cdc_done`, and `irq` is checked at the following falling edge. Register reads return data one edge after `bus_rd`. The driver queues each expected word, and a monitor pops it when it sees the read strobe that was registered at the previous edge. This means every comparison lands in the cycle the data is due.

// File: rtl/ecc_csr_pkg.sv
// Package: shared register addresses, field positions and types for the
// ECC control and status unit. Assumes a 12-bit byte address space.
package ecc_csr_pkg;

    localparam int CSR_ADDR_W = 12;

    localparam logic [CSR_ADDR_W-1:0] A_CTRL = 12'h100;
    localparam logic [CSR_ADDR_W-1:0] A_DATA = 12'h104;
    localparam logic [CSR_ADDR_W-1:0] A_PAR  = 12'h108;
    localparam logic [CSR_ADDR_W-1:0] A_STAT = 12'h114;
    localparam logic [CSR_ADDR_W-1:0] A_IEN  = 12'h118;
    localparam logic [CSR_ADDR_W-1:0] A_ERR  = 12'h11C;

    localparam int PAR_BYTES = 9;
    localparam int PAR_W     = 8 * PAR_BYTES;
    localparam int PAR_WORDS = (PAR_BYTES + 3) / 4;
    localparam int CNT_FLD_W = 3;
    localparam int CNT_LSB   = 29;

    localparam int S_ERR = 0;
    localparam int S_UNC = 1;
    localparam int S_ENC = 2;
    localparam int S_DEC = 3;
    localparam int S_PAD = 4;

    // Parity of an all-0xFF codeword, byte 0 in the low bits.
    localparam logic [PAR_W-1:0] ERASED_PAR = 72'h6F_B7_FF_8B_F4_58_90_9D_CD;

    typedef struct packed {
        logic prdy;
        logic enc;
        logic rs;
        logic rst;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/ecc_ctrl_seq.sv
// Control sequencer: holds the control word, the self-clearing reset bit,
// the data byte counter and the decode start pulse.
// Assumes only one register write per cycle on the host side.
module ecc_ctrl_seq
    import ecc_csr_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  ctrl_t       ctrl_wval,
    input  logic        data_we,
    input  logic [7:0]  data_wval,
    output ctrl_t       ctrl_q,
    output logic        clr_pulse,
    output logic        start_pulse,
    output logic        byte_vld,
    output logic [7:0]  byte_q,
    output logic        pad_hit
);
    localparam int CNT_W = $clog2(BLOCK_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLOCK_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLOCK_BYTES - 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept    = data_we && ctrl_q.en && (cnt < CNT_FULL);
    assign pad_hit   = accept && (cnt == CNT_LAST);
    assign clr_pulse = ctrl_q.rst;

    // Control word: load on write, reset bit drops by itself otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wval;
        end else begin
            ctrl_q.rst <= 1'b0;
        end
    end

    // Byte counter: cleared by the local reset, saturates at a full codeword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ctrl_we && ctrl_wval.rst) begin
            cnt <= '0;
        end else if (accept) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Forward accepted data bytes to the codec one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= accept;
            if (accept) byte_q <= data_wval;
        end
    end

    // Decode start: parity-ready rising while enabled in decode direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= ctrl_we && ctrl_wval.prdy && !ctrl_q.prdy
                           && ctrl_wval.en && !ctrl_wval.enc;
        end
    end

    a_r3_rst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.rst && !ctrl_we) |=> !ctrl_q.rst);
    a_r3_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> (cnt == '0));
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL);
    a_r8_start_decode_only: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (ctrl_q.en && !ctrl_q.enc && ctrl_q.prdy));
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

endmodule

// File: rtl/ecc_erased_sub.sv
// Erased-page substitution: replaces the parity of an all-0xFF codeword
// with all-ones so erased pages keep blank parity. Purely combinational.
module ecc_erased_sub
    import ecc_csr_pkg::*;
(
    input  logic [PAR_W-1:0] raw_par,
    output logic [PAR_W-1:0] fixed_par
);
    logic is_erased;

    // Compare against the known erased-page parity and substitute.
    always_comb begin
        is_erased = (raw_par == ERASED_PAR);
        fixed_par = is_erased ? {PAR_W{1'b1}} : raw_par;
    end

endmodule

// File: rtl/ecc_parity_bank.sv
// Parity bank: one byte register per parity byte, written by the host
// per byte or loaded whole from the codec; cleared by the local reset.
// Assumes load and host write never need to merge in one cycle (load wins).
module ecc_parity_bank #(
    parameter int NBYTES = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                load,
    input  logic [8*NBYTES-1:0] load_val,
    input  logic [NBYTES-1:0]   host_we,
    input  logic [8*NBYTES-1:0] host_val,
    output logic [8*NBYTES-1:0] par_q
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Byte i: clear, codec load or host write, in that priority.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                par_q[8*i +: 8] <= '0;
            end else if (load) begin
                par_q[8*i +: 8] <= load_val[8*i +: 8];
            end else if (host_we[i]) begin
                par_q[8*i +: 8] <= host_val[8*i +: 8];
            end
        end
    end

    a_r6_parity_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (par_q == $past(load_val)));
    a_r3_parity_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (par_q == '0));

endmodule

// File: rtl/ecc_status_bank.sv
// Status bank: sticky finish flags, decode error flags and count, the
// interrupt-enable bits, the error reports and the interrupt output.
// Assumes codec completions are single-cycle pulses.
module ecc_status_bank
    import ecc_csr_pkg::*;
#(
    parameter int NREP = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  enc_done,
    input  logic                  dec_done,
    input  logic                  pad_hit,
    input  logic                  dec_err,
    input  logic                  dec_uncor,
    input  logic [CNT_FLD_W-1:0]  dec_cnt,
    input  logic [32*NREP-1:0]    dec_rpt,
    input  logic                  stat_we,
    input  logic [4:0]            stat_wflags,
    input  logic [CNT_FLD_W-1:0]  stat_wcnt,
    input  logic                  ien_we,
    input  logic [2:0]            ien_wval,
    output logic [31:0]           stat_q,
    output logic [31:0]           ien_q,
    output logic [32*NREP-1:0]    rpt_q,
    output logic                  irq
);
    logic [4:0]           flags;
    logic [4:0]           kept;
    logic [CNT_FLD_W-1:0] cnt_q;
    logic [2:0]           ien;

    // Flags that survive the current host write (write 0 clears).
    always_comb begin
        kept = stat_we ? (flags & stat_wflags) : flags;
    end

    // Flag update: codec events set or load, host write clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            cnt_q <= '0;
        end else begin
            flags[S_ENC] <= kept[S_ENC] | enc_done;
            flags[S_DEC] <= kept[S_DEC] | dec_done;
            flags[S_PAD] <= kept[S_PAD] | pad_hit;
            flags[S_ERR] <= dec_done ? dec_err   : kept[S_ERR];
            flags[S_UNC] <= dec_done ? dec_uncor : kept[S_UNC];
            if (dec_done)     cnt_q <= dec_cnt;
            else if (stat_we) cnt_q <= cnt_q & stat_wcnt;
        end
    end

    // Interrupt-enable bits for the three finish flags.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= '0;
        else if (ien_we) ien <= ien_wval;
    end

    for (genvar i = 0; i < NREP; i++) begin : g_rpt
        // Report i: loaded on decode completion when inside the count.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                rpt_q[32*i +: 32] <= '0;
            end else if (dec_done) begin
                rpt_q[32*i +: 32] <= (CNT_FLD_W'(i) < dec_cnt) ? dec_rpt[32*i +: 32] : 32'd0;
            end
        end
    end

    // Assemble the readable words and the masked interrupt.
    always_comb begin
        stat_q = '0;
        stat_q[4:0] = flags;
        stat_q[CNT_LSB +: CNT_FLD_W] = cnt_q;
        ien_q = '0;
        ien_q[S_PAD:S_ENC] = ien;
        irq = |(flags[S_PAD:S_ENC] & ien);
    end

    a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && stat_wflags == '0 && stat_wcnt == '0
         && !enc_done && !dec_done && !pad_hit) |=> (stat_q == 32'd0));
    a_r9_dec_load: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> (stat_q[S_DEC] && stat_q[CNT_LSB +: CNT_FLD_W] == $past(dec_cnt)));
    a_r6_enc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        enc_done |=> stat_q[S_ENC]);

endmodule

// File: rtl/ecc_ctrl_status.sv
// ECC control and status unit top: decodes host register accesses, wires
// the sequencer, parity bank, erased-page substitution and status bank,
// and returns read data one cycle after the read strobe.
// Assumes word-aligned addresses and at most one access per cycle.
module ecc_ctrl_status
    import ecc_csr_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int NREP        = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [CSR_ADDR_W-1:0] bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [3:0]            bus_wstrb,
    output logic [31:0]           bus_rdata,
    output logic                  irq,
    output logic                  cdc_clear,
    output logic                  cdc_rs_sel,
    output logic                  cdc_encode,
    output logic                  cdc_byte_vld,
    output logic [7:0]            cdc_byte,
    output logic                  cdc_start,
    output logic [PAR_W-1:0]      cdc_par_out,
    input  logic                  cdc_done,
    input  logic [PAR_W-1:0]      cdc_par_in,
    input  logic                  cdc_err,
    input  logic                  cdc_uncor,
    input  logic [CNT_FLD_W-1:0]  cdc_err_cnt,
    input  logic [32*NREP-1:0]    cdc_err_rpt
);
    localparam int PAD_W = 32 * PAR_WORDS;

    ctrl_t              ctrl_q;
    logic               ctrl_we, data_we, stat_we, ien_we;
    logic               pad_hit, done_ok, enc_done, dec_done;
    logic [PAR_BYTES-1:0] host_we;
    logic [PAR_W-1:0]   host_val;
    logic [PAR_W-1:0]   par_q, par_fixed;
    logic [PAD_W-1:0]   par_pad;
    logic [31:0]        stat_q, ien_q, rd_next;
    logic [32*NREP-1:0] rpt_q;

    // Decode the single-register writes.
    always_comb begin
        ctrl_we = bus_wr && (bus_addr == A_CTRL) && bus_wstrb[0];
        data_we = bus_wr && (bus_addr == A_DATA) && bus_wstrb[0];
        stat_we = bus_wr && (bus_addr == A_STAT);
        ien_we  = bus_wr && (bus_addr == A_IEN);
    end

    for (genvar i = 0; i < PAR_BYTES; i++) begin : g_host_par
        localparam logic [CSR_ADDR_W-1:0] WADDR = A_PAR + CSR_ADDR_W'(4 * (i / 4));
        assign host_we[i]         = bus_wr && (bus_addr == WADDR) && bus_wstrb[i % 4];
        assign host_val[8*i +: 8] = bus_wdata[8*(i % 4) +: 8];
    end

    // Qualify codec completions by enable and direction.
    always_comb begin
        done_ok  = cdc_done && ctrl_q.en;
        enc_done = done_ok && ctrl_q.enc;
        dec_done = done_ok && !ctrl_q.enc;
    end

    ecc_ctrl_seq #(
        .BLOCK_BYTES (BLOCK_BYTES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .ctrl_wval   (ctrl_t'(bus_wdata[4:0])),
        .data_we     (data_we),
        .data_wval   (bus_wdata[7:0]),
        .ctrl_q      (ctrl_q),
        .clr_pulse   (cdc_clear),
        .start_pulse (cdc_start),
        .byte_vld    (cdc_byte_vld),
        .byte_q      (cdc_byte),
        .pad_hit     (pad_hit)
    );

    ecc_erased_sub i_sub (
        .raw_par   (cdc_par_in),
        .fixed_par (par_fixed)
    );

    ecc_parity_bank #(
        .NBYTES (PAR_BYTES)
    ) i_par (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cdc_clear),
        .load     (enc_done),
        .load_val (par_fixed),
        .host_we  (host_we),
        .host_val (host_val),
        .par_q    (par_q)
    );

    ecc_status_bank #(
        .NREP (NREP)
    ) i_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (cdc_clear),
        .enc_done    (enc_done),
        .dec_done    (dec_done),
        .pad_hit     (pad_hit),
        .dec_err     (cdc_err),
        .dec_uncor   (cdc_uncor),
        .dec_cnt     (cdc_err_cnt),
        .dec_rpt     (cdc_err_rpt),
        .stat_we     (stat_we),
        .stat_wflags (bus_wdata[4:0]),
        .stat_wcnt   (bus_wdata[CNT_LSB +: CNT_FLD_W]),
        .ien_we      (ien_we),
        .ien_wval    (bus_wdata[S_PAD:S_ENC]),
        .stat_q      (stat_q),
        .ien_q       (ien_q),
        .rpt_q       (rpt_q),
        .irq         (irq)
    );

    assign cdc_rs_sel  = ctrl_q.rs;
    assign cdc_encode  = ctrl_q.enc;
    assign cdc_par_out = par_q;
    assign par_pad     = {{(PAD_W - PAR_W){1'b0}}, par_q};

    // Read multiplexer over all readable words.
    always_comb begin
        rd_next = '0;
        if (bus_addr == A_CTRL) rd_next = {27'd0, ctrl_q};
        if (bus_addr == A_STAT) rd_next = stat_q;
        if (bus_addr == A_IEN)  rd_next = ien_q;
        for (int w = 0; w < PAR_WORDS; w++) begin
            if (bus_addr == A_PAR + CSR_ADDR_W'(4 * w)) rd_next = par_pad[32*w +: 32];
        end
        for (int r = 0; r < NREP; r++) begin
            if (bus_addr == A_ERR + CSR_ADDR_W'(4 * r)) rd_next = rpt_q[32*r +: 32];
        end
    end

    // Register the read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    a_r10_ignore_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_done && !ctrl_q.en && !stat_we) |=> (stat_q == $past(stat_q)));

endmodule

// File: tb/test_ecc_ctrl_status.sv
`timescale 1ns/1ps
module test_ecc_ctrl_status;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [3:0]   bus_wstrb = '0;
    logic [31:0]  bus_rdata;
    logic         irq, cdc_clear, cdc_rs_sel, cdc_encode, cdc_byte_vld, cdc_start;
    logic [7:0]   cdc_byte;
    logic [71:0]  cdc_par_out;
    logic         cdc_done = 1'b0, cdc_err = 1'b0, cdc_uncor = 1'b0;
    logic [71:0]  cdc_par_in = '0;
    logic [2:0]   cdc_err_cnt = '0;
    logic [127:0] cdc_err_rpt = '0;

    int n_tests = 0;
    int n_fail  = 0;
    logic finished = 1'b0;

    logic [31:0] q_exp[$];
    string       q_tag[$];
    logic        rd_q = 1'b0;

    always #2.5 clk = ~clk;

    ecc_ctrl_status i_ecc_ctrl_status (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .bus_rdata(bus_rdata), .irq(irq), .cdc_clear(cdc_clear),
        .cdc_rs_sel(cdc_rs_sel), .cdc_encode(cdc_encode),
        .cdc_byte_vld(cdc_byte_vld), .cdc_byte(cdc_byte), .cdc_start(cdc_start),
        .cdc_par_out(cdc_par_out), .cdc_done(cdc_done), .cdc_par_in(cdc_par_in),
        .cdc_err(cdc_err), .cdc_uncor(cdc_uncor), .cdc_err_cnt(cdc_err_cnt),
        .cdc_err_rpt(cdc_err_rpt)
    );

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    // Driver: issue a read and queue its expected word for the monitor.
    task automatic expect_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic codec_done(input logic [71:0] par, input logic e, input logic u,
                              input logic [2:0] c, input logic [127:0] rpt);
        @(negedge clk);
        cdc_done = 1'b1; cdc_par_in = par; cdc_err = e; cdc_uncor = u;
        cdc_err_cnt = c; cdc_err_rpt = rpt;
        @(negedge clk);
        cdc_done = 1'b0;
    endtask

    // Monitor: the read registered at the last edge is compared here.
    always @(posedge clk) rd_q <= bus_rd;
    always @(negedge clk) begin
        if (rd_q) begin
            if (q_exp.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL scoreboard: read with empty queue actual %h expected none", bus_rdata);
            end else begin
                chk(q_tag.pop_front(), {40'd0, bus_rdata}, {40'd0, q_exp.pop_front()});
            end
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 cdc_start", cdc_start, 0);
        expect_read(12'h100, 32'h0, "R1 ctrl");
        expect_read(12'h114, 32'h0, "R1 status");
        expect_read(12'h118, 32'h0, "R1 ien");
        expect_read(12'h108, 32'h0, "R1 parity0");
        expect_read(12'h11C, 32'h0, "R1 report0");

        // R4 data ignored while disabled
        bus_write(12'h104, 32'h5A, 4'h1);
        chk("R4 disabled byte_vld", cdc_byte_vld, 0);

        // R2 control fields
        bus_write(12'h100, 32'h0D, 4'h1);
        expect_read(12'h100, 32'h0D, "R2 ctrl readback");
        chk("R2 cdc_encode", cdc_encode, 1);
        chk("R2 cdc_rs_sel", cdc_rs_sel, 1);

        // R4 forwarding, R5 pad finished at the 512th byte
        bus_write(12'h104, 32'hA5, 4'h1);
        chk("R4 byte_vld", cdc_byte_vld, 1);
        chk("R4 byte", cdc_byte, 8'hA5);
        for (int k = 1; k < 512; k++) bus_write(12'h104, 32'(k & 8'hFF), 4'h1);
        expect_read(12'h114, 32'h10, "R5 pad flag");
        bus_write(12'h104, 32'h33, 4'h1);
        chk("R5 byte after full block", cdc_byte_vld, 0);

        // R6 encode completion, R12 interrupt mask
        codec_done(72'h09_08070605_04030201, 0, 0, 0, '0);
        chk("R12 irq masked", irq, 0);
        expect_read(12'h108, 32'h04030201, "R6 parity word0");
        expect_read(12'h10C, 32'h08070605, "R6 parity word1");
        expect_read(12'h110, 32'h00000009, "R6 parity word2");
        expect_read(12'h114, 32'h14, "R6 status enc+pad");
        bus_write(12'h118, 32'h04, 4'hF);
        chk("R12 irq enc enabled", irq, 1);
        expect_read(12'h118, 32'h04, "R12 ien readback");

        // R11 write 0 clears
        bus_write(12'h114, 32'h0, 4'hF);
        chk("R11 irq after clear", irq, 0);
        expect_read(12'h114, 32'h0, "R11 status cleared");

        // R7 erased-page substitution
        codec_done(72'h6F_B7_FF_8B_F4_58_90_9D_CD, 0, 0, 0, '0);
        expect_read(12'h108, 32'hFFFFFFFF, "R7 parity word0");
        expect_read(12'h110, 32'h000000FF, "R7 parity word2");
        bus_write(12'h114, 32'h0, 4'hF);

        // R3 local reset
        bus_write(12'h100, 32'h0F, 4'h1);
        chk("R3 cdc_clear pulse", cdc_clear, 1);
        expect_read(12'h100, 32'h0D, "R3 reset bit dropped");
        chk("R3 cdc_clear low", cdc_clear, 0);
        expect_read(12'h108, 32'h0, "R3 parity cleared");
        bus_write(12'h104, 32'h77, 4'h1);
        chk("R3 counter cleared byte_vld", cdc_byte_vld, 1);

        // R8 decode start with host-written parity
        bus_write(12'h100, 32'h05, 4'h1);
        bus_write(12'h108, 32'h44332211, 4'hF);
        bus_write(12'h10C, 32'h88776655, 4'hF);
        bus_write(12'h110, 32'h00000099, 4'h1);
        bus_write(12'h10C, 32'h0000EE00, 4'h2);
        expect_read(12'h10C, 32'h8877EE55, "R8 byte strobe write");
        bus_write(12'h100, 32'h15, 4'h1);
        chk("R8 cdc_start", cdc_start, 1);
        chk("R8 cdc_par_out", cdc_par_out, 72'h99_8877EE55_44332211);
        @(negedge clk);
        chk("R8 start one cycle", cdc_start, 0);

        // R9 decode completion
        codec_done('0, 1, 0, 3'd2, {32'hBEEF, 32'hDEAD, 32'h01230101, 32'h00050003});
        expect_read(12'h114, 32'h40000009, "R9 status");
        expect_read(12'h11C, 32'h00050003, "R9 report0");
        expect_read(12'h120, 32'h01230101, "R9 report1");
        expect_read(12'h124, 32'h0, "R9 report2 beyond count");
        chk("R12 irq dec masked", irq, 0);
        bus_write(12'h118, 32'h08, 4'hF);
        chk("R12 irq dec enabled", irq, 1);

        // R11 partial clear keeps bits written 1
        bus_write(12'h114, 32'hFFFFFFF7, 4'hF);
        expect_read(12'h114, 32'h40000001, "R11 partial clear");
        chk("R11 irq after partial", irq, 0);

        // R10 completion ignored when disabled
        bus_write(12'h100, 32'h04, 4'h1);
        codec_done('0, 1, 1, 3'd3, {4{32'h12345678}});
        expect_read(12'h114, 32'h40000001, "R10 status unchanged");
        expect_read(12'h11C, 32'h00050003, "R10 report unchanged");

        // R8 no start in encode mode
        bus_write(12'h100, 32'h0D, 4'h1);
        bus_write(12'h100, 32'h1D, 4'h1);
        chk("R8 no start encode", cdc_start, 0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule